// File: doc/BRIEF.md
# Sticky Status and Alert Controller

This block gathers level-type out-of-limit indications from a set of monitored channels and latches each one into a sticky status bit. The bits are presented to software as two status registers of `REG_W` bits each. The first register holds `REG_W-1` channel bits, and its top bit summarises the second register. The second register holds `REG_W` channel bits. A bit stays set after its channel recovers, so a polling host cannot miss a short excursion. A read of a register clears only those bits whose channel has recovered by the time of the read.

Each channel also has a mask bit. A set mask bit keeps that channel from pulling the active-low alert output. The status bit itself is still recorded. The alert stays low for as long as any unmasked status bit is set. The bus front end that decodes register accesses and the limit comparators are outside this block. Their results arrive as plain one-cycle strobes and condition levels. The block has no data stream, so every pin is a plain control or status pin with no valid/ready handshake.

Top module: `sticky_alert_ctrl`

## Requirements
- R1: While `mon_start_i` is 1, a channel whose condition input is 1 at a rising clock edge has its status bit set to 1 after that edge. Condition bits `oor_i[REG_W-2:0]` map to `stat1_o[REG_W-2:0]`, and `oor_i[2*REG_W-2:REG_W-1]` map to `stat2_o[REG_W-1:0]`.
- R2: A status bit that is set stays set when its condition goes back to 0, for as long as its register is not read.
- R3: A read strobe (`rd_stat1_i` for register 1, `rd_stat2_i` for register 2) clears a set bit of that register only if the bit's condition is 0 in the same cycle. Otherwise the bit stays set, because a set wins over a clear. A read strobe has no effect on the bits of the other register.
- R4: While `mon_start_i` is 0, no status bit becomes set. Bits that are already set keep their value, and reads still clear them under the rule of R3.
- R5: A mask bit of 1 stops its channel from driving the alert. The channel's status bit is still set and held exactly as in R1 to R3.
- R6: `stat1_o[REG_W-1]` is 1 exactly when any bit of `stat2_o` is 1. It is not a stored bit, so a read of register 1 never changes it.
- R7: `alert_n_o` is 0 exactly when at least one status bit with a mask bit of 0 is set. `mask1_we_i` loads `mask_wdata_i[REG_W-2:0]` as the masks of register 1 and ignores the top data bit. `mask2_we_i` loads `mask_wdata_i[REG_W-1:0]` as the masks of register 2. A new mask takes effect on the alert after the writing edge.
- R8: After reset, all status and mask bits are 0, and `alert_n_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mon_start_i | input | 1 | Monitoring enable; status bits can be set only while this is 1 |
| oor_i | input | 2*REG_W-1 | Per-channel out-of-limit level |
| rd_stat1_i | input | 1 | One-cycle strobe: status register 1 is being read |
| rd_stat2_i | input | 1 | One-cycle strobe: status register 2 is being read |
| mask1_we_i | input | 1 | Write strobe for the register 1 masks |
| mask2_we_i | input | 1 | Write strobe for the register 2 masks |
| mask_wdata_i | input | REG_W | Mask write data |
| stat1_o | output | REG_W | Status register 1 read data, with the summary bit on top |
| stat2_o | output | REG_W | Status register 2 read data |
| alert_n_o | output | 1 | Alert, active low |

## Verification
The bench builds the block with the default `REG_W = 8`, which gives 15 channels split 7 and 8 across the two registers. Because the register split is this uneven, the bench can check the summary bit and the ignored top bit of the register 1 mask write. With only 15 channels, random condition patterns often make a read and a set meet on the same bit in the same cycle. Random masks of 15 bits often leave exactly one unmasked source active, which exercises the alert at its one-bit edge.

// File: rtl/stat_alert_pkg.sv
package stat_alert_pkg;
  localparam int unsigned DEF_REG_W = 8;

  function automatic int unsigned src_count(input int unsigned reg_w);
    return 2 * reg_w - 1;
  endfunction
endpackage

// File: rtl/flag_bank.sv
module flag_bank #(
  parameter int unsigned REG_W = 8,
  localparam int unsigned SRC_N = 2 * REG_W - 1,
  localparam int unsigned LOW_N = REG_W - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mon_en,
  input  logic [SRC_N-1:0] cond,
  input  logic             rd_lo,
  input  logic             rd_hi,
  output logic [SRC_N-1:0] flags
);
  logic [SRC_N-1:0] clr_req;
  logic [SRC_N-1:0] clr_ok;

  for (genvar i = 0; i < SRC_N; i++) begin : g_flag
    if (i < LOW_N) begin : g_lo
      assign clr_req[i] = rd_lo;
    end else begin : g_hi
      assign clr_req[i] = rd_hi;
    end
    assign clr_ok[i] = clr_req[i] & ~cond[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                flags[i] <= 1'b0;
      else if (mon_en && cond[i]) flags[i] <= 1'b1;
      else if (clr_ok[i])        flags[i] <= 1'b0;
    end
  end

  // R1
  set_on_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mon_en |=> ((flags & $past(cond)) == $past(cond)));
  // R2
  hold_unread_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags & $past(flags & ~clr_req)) == $past(flags & ~clr_req)));
  // R4
  no_set_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mon_en |=> ((flags & ~$past(flags)) == '0));
endmodule

// File: rtl/mask_store.sv
module mask_store #(
  parameter int unsigned REG_W = 8,
  localparam int unsigned SRC_N = 2 * REG_W - 1,
  localparam int unsigned LOW_N = REG_W - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_lo,
  input  logic             we_hi,
  input  logic [REG_W-1:0] wdata,
  output logic [SRC_N-1:0] mask
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask <= '0;
    end else begin
      if (we_lo) mask[LOW_N-1:0]     <= wdata[LOW_N-1:0];
      if (we_hi) mask[SRC_N-1:LOW_N] <= wdata;
    end
  end
endmodule

// File: rtl/alert_drv.sv
module alert_drv #(
  parameter int unsigned SRC_N = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_N-1:0] flags,
  input  logic [SRC_N-1:0] mask,
  output logic             alert_n
);
  assign alert_n = ~|(flags & ~mask);

  // R7
  alert_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !alert_n |-> (flags != '0));
  // R5
  full_mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask) |-> alert_n);
endmodule

// File: rtl/sticky_alert_ctrl.sv
module sticky_alert_ctrl #(
  parameter int unsigned REG_W = stat_alert_pkg::DEF_REG_W,
  localparam int unsigned SRC_N = stat_alert_pkg::src_count(REG_W),
  localparam int unsigned LOW_N = REG_W - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mon_start_i,
  input  logic [SRC_N-1:0] oor_i,
  input  logic             rd_stat1_i,
  input  logic             rd_stat2_i,
  input  logic             mask1_we_i,
  input  logic             mask2_we_i,
  input  logic [REG_W-1:0] mask_wdata_i,
  output logic [REG_W-1:0] stat1_o,
  output logic [REG_W-1:0] stat2_o,
  output logic             alert_n_o
);
  logic [SRC_N-1:0] flags;
  logic [SRC_N-1:0] mask;

  flag_bank #(.REG_W(REG_W)) i_flags (
    .clk(clk), .rst_n(rst_n), .mon_en(mon_start_i), .cond(oor_i),
    .rd_lo(rd_stat1_i), .rd_hi(rd_stat2_i), .flags(flags)
  );

  mask_store #(.REG_W(REG_W)) i_mask (
    .clk(clk), .rst_n(rst_n), .we_lo(mask1_we_i), .we_hi(mask2_we_i),
    .wdata(mask_wdata_i), .mask(mask)
  );

  alert_drv #(.SRC_N(SRC_N)) i_alert (
    .clk(clk), .rst_n(rst_n), .flags(flags), .mask(mask), .alert_n(alert_n_o)
  );

  assign stat2_o = flags[SRC_N-1:LOW_N];
  assign stat1_o = {|flags[SRC_N-1:LOW_N], flags[LOW_N-1:0]};

  // R3
  rd1_spares_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat1_i && !rd_stat2_i) |=> ((stat2_o & $past(stat2_o)) == $past(stat2_o)));
endmodule

// File: tb/test_sticky_alert_ctrl.sv
module test_sticky_alert_ctrl;
  localparam int unsigned REG_W = 8;
  localparam int unsigned SRC_N = 2 * REG_W - 1;
  localparam int unsigned LOW_N = REG_W - 1;
  localparam time CLK_PERIOD = 10ns;
  localparam int unsigned WATCHDOG = 50000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mon_start_i = 1'b0;
  logic [SRC_N-1:0] oor_i = '0;
  logic rd_stat1_i = 1'b0, rd_stat2_i = 1'b0;
  logic mask1_we_i = 1'b0, mask2_we_i = 1'b0;
  logic [REG_W-1:0] mask_wdata_i = '0;
  logic [REG_W-1:0] stat1_o, stat2_o;
  logic alert_n_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [SRC_N-1:0] m_flag = '0;
  logic [SRC_N-1:0] m_mask = '0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sticky_alert_ctrl #(.REG_W(REG_W)) i_sticky_alert_ctrl (.*);

  function automatic logic [REG_W-1:0] exp_s1(input logic [SRC_N-1:0] f);
    return {|f[SRC_N-1:LOW_N], f[LOW_N-1:0]};
  endfunction

  function automatic logic exp_alert(input logic [SRC_N-1:0] f, input logic [SRC_N-1:0] m);
    return ~|(f & ~m);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    check({tag, " stat1"}, 32'(stat1_o), 32'(exp_s1(m_flag)));
    check({tag, " stat2"}, 32'(stat2_o), 32'(m_flag[SRC_N-1:LOW_N]));
    check({tag, " alert"}, 32'(alert_n_o), 32'(exp_alert(m_flag, m_mask)));
  endtask

  // Entered at a falling edge: drive, advance the model, check at the next falling edge.
  task automatic step(input logic en, input logic [SRC_N-1:0] c, input logic r1,
                      input logic r2, input logic w1, input logic w2,
                      input logic [REG_W-1:0] wd, input string tag);
    logic [SRC_N-1:0] clr;
    mon_start_i = en; oor_i = c; rd_stat1_i = r1; rd_stat2_i = r2;
    mask1_we_i = w1; mask2_we_i = w2; mask_wdata_i = wd;
    clr = {{REG_W{r2}}, {LOW_N{r1}}};
    m_flag = (m_flag & ~(clr & ~c)) | (en ? c : '0);
    if (w1) m_mask[LOW_N-1:0] = wd[LOW_N-1:0];
    if (w2) m_mask[SRC_N-1:LOW_N] = wd;
    @(negedge clk);
    check_all(tag);
  endtask

  initial begin
    for (int n = 0; n < WATCHDOG; n++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check_all("R8 reset");
    rst_n = 1'b1;
    @(negedge clk);
    // R1 set bit 3 of register 1
    step(1, 15'h0008, 0, 0, 0, 0, 8'h00, "R1 set");
    // R2 condition gone, no read
    step(1, 15'h0000, 0, 0, 0, 0, 8'h00, "R2 hold");
    // R3 read with condition present: stays (set wins)
    step(1, 15'h0008, 1, 0, 0, 0, 8'h00, "R3 read while active");
    // R3 read with condition gone: cleared
    step(1, 15'h0000, 1, 0, 0, 0, 8'h00, "R3 read after recovery");
    // R6 set a register 2 bit, summary appears; read register 1 leaves it
    step(1, 15'h0100, 0, 0, 0, 0, 8'h00, "R6 summary set");
    step(1, 15'h0000, 1, 0, 0, 0, 8'h00, "R6 rd1 keeps summary");
    // R3 read of register 2 after recovery
    step(1, 15'h0000, 0, 1, 0, 0, 8'h00, "R3 rd2 clears");
    // R4 monitoring off: no set
    step(0, 15'h7FFF, 0, 0, 0, 0, 8'h00, "R4 disabled");
    // R7 mask write of register 1, top data bit ignored
    step(0, 15'h0000, 0, 0, 1, 0, 8'hFF, "R7 mask1 write");
    // R5 masked source still sets its status bit
    step(1, 15'h0001, 0, 0, 0, 0, 8'h00, "R5 masked set");
    // R7 unmasked register 2 source pulls alert
    step(1, 15'h0080, 0, 0, 0, 0, 8'h00, "R7 alert low");
    step(1, 15'h0000, 0, 0, 0, 1, 8'h01, "R7 mask2 hides it");
    step(0, 15'h0000, 1, 1, 1, 1, 8'h00, "R4 clears while idle");
    for (int k = 0; k < 3000; k++) begin
      logic [SRC_N-1:0] c;
      c = SRC_N'($urandom) & SRC_N'($urandom);
      step(($urandom % 8) != 0, c, ($urandom % 4) == 0, ($urandom % 4) == 0,
           ($urandom % 16) == 0, ($urandom % 16) == 0, REG_W'($urandom),
           "R1/R2/R3/R5/R6/R7 random");
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule